// File: doc/BRIEF.md
# Stack Frame Register Restore Sequencer

This block carries out the return side of a multi-register call frame for a small 32-bit processor. A single start strobe hands it the current stack pointer, an 8-bit frame-release amount, a four-bit selection of optional data and address registers, and the current return-address register value. A variant input picks where the new program counter comes from.

It first releases the frame by adding the zero-extended amount to the stack pointer and writes the result back. It then loads the program counter in one of two ways. In the fast variant it takes the return-address register value directly. In the memory variant it takes the word stored at the released stack pointer.

After that it walks downward from the released pointer, reading one 32-bit word per slot, and writes each word into the register file. The selected optional registers come first. A fixed group of seven registers always follows, and that group includes the loop-control and return-address registers. Reads use a ready-qualified request port. Read data may return any number of cycles later, but always in request order. A busy level covers the whole operation and a one-cycle done pulse marks its end.

Top module: `frame_restore_seq`

## Requirements
- R1: While reset is asserted and directly after it, busy_o, done_o, mem_req_o, sp_we_o, pc_we_o and rf_we_o are all low.
- R2: A start accepted while idle raises sp_we_o for exactly one cycle, in the cycle after the start. In that cycle sp_o equals sp_i plus adj_i zero-extended to 32 bits, modulo 2^32.
- R3: With fast_i high at start, pc_we_o pulses in the same cycle as sp_we_o and pc_o equals ret_addr_i. No read is made of the slot at the released stack pointer.
- R4: With fast_i low at start, the first read goes to the released stack pointer. The data returned for that read is written to pc_o with a pc_we_o pulse.
- R5: Register reads go to the released stack pointer minus 4, minus 8, minus 12 and so on, one 4-byte step per restored register.
- R6: Register identifiers on rf_id_o are D2=0, D3=1, A2=2, A3=3, D0=4, D1=5, A0=6, A1=7, return-address=8, loop-instruction=9, loop-address=10. mask_i bit 3 selects D2, bit 2 selects D3, bit 1 selects A2 and bit 0 selects A3. Selected registers are restored in ascending identifier order, followed always by identifiers 4 through 10 in ascending order.
- R7: An unselected optional register takes no stack slot. The number of reads equals the number of set mask bits plus 7, plus 1 in the memory variant, and mem_req_o stays low after the last of them.
- R8: mem_req_o is high only while busy. A read is accepted in a cycle where mem_req_o and mem_rdy_i are both high, at most one per cycle. While mem_rdy_i is low, the request and its address stay unchanged.
- R9: Each mem_rvalid_i that answers an outstanding read produces, in the next cycle, exactly one write of mem_rdata_i, to the destination of the oldest unanswered read. mem_rvalid_i with no read outstanding has no effect.
- R10: busy_o stays high from the cycle after the start up to and including the cycle of the final write. done_o is high for the single following cycle with busy_o low. A start raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame return (taken only while idle) |
| fast_i | input | 1 | 1: PC from ret_addr_i; 0: PC from memory |
| sp_i | input | 32 | Current stack pointer |
| adj_i | input | 8 | Frame release amount, unsigned |
| mask_i | input | 4 | Optional register selection (D2, D3, A2, A3 on bits 3..0) |
| ret_addr_i | input | 32 | Current return-address register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | 32 | Released stack pointer |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | 32 | New program counter |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read address |
| mem_rdy_i | input | 1 | Read port accepts the request |
| mem_rvalid_i | input | 1 | Read data valid (in request order) |
| mem_rdata_i | input | 32 | Read data |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_id_o | output | 4 | Register identifier to write |
| rf_data_o | output | 32 | Register-file write data |

## Verification
A corrupted issue index shows up on mem_addr_o at the very next request cycle. It appears as an address that is off by a multiple of four, or as a request that stops early or runs on past the list. A corrupted answer index or captured register list appears on rf_id_o in the cycle right after the next read answer. A wrong list length or finish flag moves busy_o and done_o away from the cycle after the last write. Because the reference model is compared on every clock, each of these faults is caught within one or two cycles of the state going wrong.

// File: rtl/frs_pkg.sv
package frs_pkg;
    localparam int ID_W    = 4;
    localparam int FIXED_N = 7;
    typedef logic [ID_W-1:0] reg_id_t;
    localparam reg_id_t ID_PC = '1;
endpackage

// File: rtl/frs_order_builder.sv
module frs_order_builder
    import frs_pkg::*;
#(
    parameter int USER_N   = 4,
    parameter int LIST_MAX = USER_N + FIXED_N + 1,
    parameter int CNT_W    = $clog2(LIST_MAX + 1)
) (
    input  logic                          fast_i,
    input  logic [USER_N-1:0]             mask_i,
    output reg_id_t [LIST_MAX-1:0]        list_o,
    output logic [CNT_W-1:0]              count_o
);
    // Destination list in request order: optional PC slot, selected
    // optional registers (highest mask bit first), then the fixed group.
    logic [USER_N-1:0] sel_ordered;

    genvar g;
    generate
        for (g = 0; g < USER_N; g++) begin : g_rev
            assign sel_ordered[g] = mask_i[USER_N-1-g];
        end
    endgenerate

    always_comb begin
        logic [CNT_W-1:0] pos;
        list_o = '0;
        pos    = '0;
        if (!fast_i) begin
            list_o[pos] = ID_PC;
            pos = pos + CNT_W'(1);
        end
        for (int j = 0; j < USER_N; j++) begin
            if (sel_ordered[j]) begin
                list_o[pos] = reg_id_t'(j);
                pos = pos + CNT_W'(1);
            end
        end
        for (int k = 0; k < FIXED_N; k++) begin
            list_o[pos] = reg_id_t'(USER_N + k);
            pos = pos + CNT_W'(1);
        end
        count_o = pos;
    end
endmodule

// File: rtl/frs_addr_gen.sv
module frs_addr_gen #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic [WORD_W-1:0] base_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic [WORD_W-1:0] addr_o
);
    // Each slot is one 4-byte word below the previous one.
    assign addr_o = base_i - (WORD_W'(idx_i) << 2);
endmodule

// File: rtl/frame_restore_seq.sv
module frame_restore_seq
    import frs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADJ_W  = 8,
    parameter int USER_N = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic                 fast_i,
    input  logic [WORD_W-1:0]    sp_i,
    input  logic [ADJ_W-1:0]     adj_i,
    input  logic [USER_N-1:0]    mask_i,
    input  logic [WORD_W-1:0]    ret_addr_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 sp_we_o,
    output logic [WORD_W-1:0]    sp_o,
    output logic                 pc_we_o,
    output logic [WORD_W-1:0]    pc_o,
    output logic                 mem_req_o,
    output logic [WORD_W-1:0]    mem_addr_o,
    input  logic                 mem_rdy_i,
    input  logic                 mem_rvalid_i,
    input  logic [WORD_W-1:0]    mem_rdata_i,
    output logic                 rf_we_o,
    output logic [ID_W-1:0]      rf_id_o,
    output logic [WORD_W-1:0]    rf_data_o
);
    localparam int LIST_MAX = USER_N + FIXED_N + 1;
    localparam int CNT_W    = $clog2(LIST_MAX + 1);

    typedef struct packed {
        logic                  busy;
        logic                  fin;
        logic                  done;
        logic                  sp_we;
        logic [WORD_W-1:0]     sp;
        logic                  pc_we;
        logic [WORD_W-1:0]     pc;
        logic                  rf_we;
        reg_id_t               rf_id;
        logic [WORD_W-1:0]     rf_data;
        logic [WORD_W-1:0]     base;
        logic [CNT_W-1:0]      cnt;
        logic [CNT_W-1:0]      iss;
        logic [CNT_W-1:0]      ret;
        reg_id_t [LIST_MAX-1:0] list;
    } state_t;

    state_t s_d, s_q;

    reg_id_t [LIST_MAX-1:0] bld_list;
    logic [CNT_W-1:0]       bld_cnt;
    logic [WORD_W-1:0]      slot_addr;
    logic                   req;
    logic [WORD_W-1:0]      new_sp;
    reg_id_t                ans_id;

    frs_order_builder #(
        .USER_N   (USER_N),
        .LIST_MAX (LIST_MAX),
        .CNT_W    (CNT_W)
    ) u_order (
        .fast_i  (fast_i),
        .mask_i  (mask_i),
        .list_o  (bld_list),
        .count_o (bld_cnt)
    );

    frs_addr_gen #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_addr (
        .base_i (s_q.base),
        .idx_i  (s_q.iss),
        .addr_o (slot_addr)
    );

    assign new_sp = sp_i + WORD_W'(adj_i);
    assign req    = s_q.busy && !s_q.fin && (s_q.iss != s_q.cnt);
    assign ans_id = s_q.list[s_q.ret];

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.sp_we = 1'b0;
        s_d.pc_we = 1'b0;
        s_d.rf_we = 1'b0;

        if (s_q.fin) begin
            s_d.busy = 1'b0;
            s_d.fin  = 1'b0;
            s_d.done = 1'b1;
        end else if (s_q.busy) begin
            if (req && mem_rdy_i) begin
                s_d.iss = s_q.iss + CNT_W'(1);
            end
            // An answer counts only if a read is outstanding.
            if (mem_rvalid_i && (s_q.ret != s_q.iss)) begin
                if (ans_id == ID_PC) begin
                    s_d.pc_we = 1'b1;
                    s_d.pc    = mem_rdata_i;
                end else begin
                    s_d.rf_we   = 1'b1;
                    s_d.rf_id   = ans_id;
                    s_d.rf_data = mem_rdata_i;
                end
                s_d.ret = s_q.ret + CNT_W'(1);
                if ((s_q.ret + CNT_W'(1)) == s_q.cnt) begin
                    s_d.fin = 1'b1;
                end
            end
        end else if (start_i) begin
            s_d.busy  = 1'b1;
            s_d.sp_we = 1'b1;
            s_d.sp    = new_sp;
            s_d.pc_we = fast_i;
            s_d.pc    = ret_addr_i;
            s_d.base  = fast_i ? (new_sp - WORD_W'(4)) : new_sp;
            s_d.cnt   = bld_cnt;
            s_d.list  = bld_list;
            s_d.iss   = '0;
            s_d.ret   = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign done_o     = s_q.done;
    assign sp_we_o    = s_q.sp_we;
    assign sp_o       = s_q.sp;
    assign pc_we_o    = s_q.pc_we;
    assign pc_o       = s_q.pc;
    assign mem_req_o  = req;
    assign mem_addr_o = slot_addr;
    assign rf_we_o    = s_q.rf_we;
    assign rf_id_o    = s_q.rf_id;
    assign rf_data_o  = s_q.rf_data;
endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
    parameter int WORD_W = 32,
    parameter int ID_W   = 4,
    parameter int MAX_ID = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              busy_o,
    input logic              done_o,
    input logic              sp_we_o,
    input logic              pc_we_o,
    input logic              mem_req_o,
    input logic [WORD_W-1:0] mem_addr_o,
    input logic              mem_rdy_i,
    input logic              rf_we_o,
    input logic [ID_W-1:0]   rf_id_o
);
    // R10: done follows a busy cycle and is seen with busy low
    a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10: done lasts a single cycle
    a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: a stalled request holds with its address
    a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R8: requests only while busy
    a_r8_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> busy_o);

    // R2: stack pointer write marks the first busy cycle
    a_r2_sp_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sp_we_o |-> (busy_o && !$past(busy_o)));

    // R6: register identifiers stay inside the defined set
    a_r6_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_we_o |-> (int'(rf_id_o) <= MAX_ID));

    // R9: one destination per answer
    a_r9_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rf_we_o && pc_we_o));
endmodule

bind frame_restore_seq frs_checker #(
    .WORD_W (WORD_W),
    .ID_W   (frs_pkg::ID_W),
    .MAX_ID (USER_N + frs_pkg::FIXED_N - 1)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sp_we_o    (sp_we_o),
    .pc_we_o    (pc_we_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_rdy_i  (mem_rdy_i),
    .rf_we_o    (rf_we_o),
    .rf_id_o    (rf_id_o)
);

// File: tb/frame_restore_seq_bench.sv
module frame_restore_seq_bench;
    // 4 time units per period: 250 MHz with a 1 ns unit
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_ni;
    logic        start_i, fast_i;
    logic [31:0] sp_i, ret_addr_i;
    logic [7:0]  adj_i;
    logic [3:0]  mask_i;
    logic        busy_o, done_o, sp_we_o, pc_we_o, mem_req_o, rf_we_o;
    logic [31:0] sp_o, pc_o, mem_addr_o, mem_rdata_i, rf_data_o;
    logic        mem_rdy_i, mem_rvalid_i;
    logic [3:0]  rf_id_o;

    frame_restore_seq u_frame_restore_seq (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .fast_i(fast_i),
        .sp_i(sp_i), .adj_i(adj_i), .mask_i(mask_i), .ret_addr_i(ret_addr_i),
        .busy_o(busy_o), .done_o(done_o), .sp_we_o(sp_we_o), .sp_o(sp_o),
        .pc_we_o(pc_we_o), .pc_o(pc_o), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_rdy_i(mem_rdy_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .rf_we_o(rf_we_o), .rf_id_o(rf_id_o), .rf_data_o(rf_data_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [31:0] req_q[$];
    logic [3:0]  dst_q[$];
    logic [3:0]  out_q[$];
    logic [31:0] resp_q[$];
    bit          c_busy, c_fin, c_done, c_spwe, c_pcwe, c_rfwe;
    logic [31:0] c_sp, c_pc, c_rfd;
    logic [3:0]  c_id;
    int          remaining;

    bit          g_start, g_fast, g_rdyrand, g_spur;
    logic [31:0] g_sp, g_ret;
    logic [7:0]  g_adj;
    logic [3:0]  g_mask;

    function automatic logic [31:0] data_of(logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        bit          exp_req, rdy, rv, rv_real;
        logic [31:0] rd, nsp, a;
        logic [3:0]  d;
        bit          n_busy, n_fin, n_done, n_spwe, n_pcwe, n_rfwe;
        logic [31:0] n_sp, n_pc, n_rfd;
        logic [3:0]  n_id;
        int          slot;

        @(negedge clk);
        exp_req = c_busy && !c_fin && (req_q.size() > 0);
        chk(busy_o == c_busy, "R10 busy", 32'(busy_o), 32'(c_busy));
        chk(done_o == c_done, "R10 done", 32'(done_o), 32'(c_done));
        chk(sp_we_o == c_spwe, "R2 sp_we", 32'(sp_we_o), 32'(c_spwe));
        if (c_spwe) chk(sp_o == c_sp, "R2 sp value", sp_o, c_sp);
        chk(pc_we_o == c_pcwe, g_fast ? "R3 pc_we" : "R4 pc_we", 32'(pc_we_o), 32'(c_pcwe));
        if (c_pcwe) chk(pc_o == c_pc, g_fast ? "R3 pc value" : "R4 pc value", pc_o, c_pc);
        chk(rf_we_o == c_rfwe, "R9 rf_we", 32'(rf_we_o), 32'(c_rfwe));
        if (c_rfwe) begin
            chk(rf_id_o == c_id, "R6 rf_id", 32'(rf_id_o), 32'(c_id));
            chk(rf_data_o == c_rfd, "R9 rf_data", rf_data_o, c_rfd);
        end
        chk(mem_req_o == exp_req, (req_q.size() > 0) ? "R8 mem_req" : "R7 mem_req",
            32'(mem_req_o), 32'(exp_req));
        if (exp_req && mem_req_o) chk(mem_addr_o == req_q[0], "R5 mem_addr", mem_addr_o, req_q[0]);

        // inputs for this cycle
        rdy = g_rdyrand ? ($urandom_range(2) != 0) : 1'b1;
        rv = 1'b0; rv_real = 1'b0; rd = 32'h0;
        if (resp_q.size() > 0 && $urandom_range(1) == 1) begin
            rv = 1'b1; rv_real = 1'b1; rd = data_of(resp_q[0]);
        end else if (g_spur && resp_q.size() == 0) begin
            rv = 1'b1; rd = 32'hDEAD_BEEF;
        end
        start_i = g_start; fast_i = g_fast; sp_i = g_sp; adj_i = g_adj;
        mask_i = g_mask; ret_addr_i = g_ret;
        mem_rdy_i = rdy; mem_rvalid_i = rv; mem_rdata_i = rd;

        // model of the coming edge
        n_busy = c_busy; n_fin = c_fin; n_done = 1'b0;
        n_spwe = 1'b0; n_pcwe = 1'b0; n_rfwe = 1'b0;
        n_sp = c_sp; n_pc = c_pc; n_rfd = c_rfd; n_id = c_id;
        if (c_fin) begin
            n_busy = 1'b0; n_fin = 1'b0; n_done = 1'b1;
        end else if (c_busy) begin
            if (rv_real) begin
                d = out_q.pop_front();
                a = resp_q.pop_front();
                if (d == 4'hF) begin
                    n_pcwe = 1'b1; n_pc = data_of(a);
                end else begin
                    n_rfwe = 1'b1; n_id = d; n_rfd = data_of(a);
                end
                remaining--;
                if (remaining == 0) n_fin = 1'b1;
            end
            if (req_q.size() > 0 && rdy) begin
                resp_q.push_back(req_q.pop_front());
                out_q.push_back(dst_q.pop_front());
            end
        end else if (g_start) begin
            nsp = g_sp + {24'h0, g_adj};
            n_busy = 1'b1; n_spwe = 1'b1; n_sp = nsp;
            slot = 0;
            if (g_fast) begin
                n_pcwe = 1'b1; n_pc = g_ret;
            end else begin
                req_q.push_back(nsp); dst_q.push_back(4'hF);
            end
            for (int j = 0; j < 4; j++) begin
                if (g_mask[3-j]) begin
                    slot++;
                    req_q.push_back(nsp - 32'(4 * slot)); dst_q.push_back(4'(j));
                end
            end
            for (int k = 0; k < 7; k++) begin
                slot++;
                req_q.push_back(nsp - 32'(4 * slot)); dst_q.push_back(4'(4 + k));
            end
            remaining = req_q.size();
        end
        c_busy = n_busy; c_fin = n_fin; c_done = n_done;
        c_spwe = n_spwe; c_pcwe = n_pcwe; c_rfwe = n_rfwe;
        c_sp = n_sp; c_pc = n_pc; c_rfd = n_rfd; c_id = n_id;
    endtask

    task automatic run_op(bit fast, logic [3:0] mask, logic [31:0] sp, logic [7:0] adj,
                          logic [31:0] ret, bit rdyrand, bit restart_mid, bit spur);
        int n;
        g_fast = fast; g_mask = mask; g_sp = sp; g_adj = adj; g_ret = ret;
        g_rdyrand = rdyrand; g_spur = spur;
        g_start = 1'b1;
        step();
        g_start = 1'b0;
        n = 0;
        while ((c_busy || c_done) && n < 500) begin
            // R10: a second start while busy, with other operands, must be ignored
            if (restart_mid && n == 3) begin
                g_start = 1'b1; g_sp = 32'h0BAD_0000; g_mask = ~mask;
            end else begin
                g_start = 1'b0;
            end
            step();
            n++;
        end
        g_spur = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_ni = 1'b0;
        start_i = 1'b0; fast_i = 1'b0; sp_i = '0; adj_i = '0; mask_i = '0;
        ret_addr_i = '0; mem_rdy_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        g_start = 0; g_fast = 0; g_rdyrand = 0; g_spur = 0;
        g_sp = '0; g_ret = '0; g_adj = '0; g_mask = '0;
        repeat (3) @(negedge clk);
        // R1: idle outputs in reset
        chk(!busy_o, "R1 busy", 32'(busy_o), 0);
        chk(!done_o, "R1 done", 32'(done_o), 0);
        chk(!mem_req_o, "R1 mem_req", 32'(mem_req_o), 0);
        chk(!sp_we_o && !pc_we_o && !rf_we_o, "R1 writes",
            32'({sp_we_o, pc_we_o, rf_we_o}), 0);
        rst_ni = 1'b1;
        step(); step();

        // R3 R6: fast variant, full list, always ready
        run_op(1'b1, 4'b1111, 32'h0000_1000, 8'h30, 32'hCAFE_0100, 1'b0, 1'b0, 1'b0);
        // R4 R7: memory variant, no optional registers, stalling port, stray answers
        run_op(1'b0, 4'b0000, 32'h2000_0040, 8'h24, 32'h1111_2222, 1'b1, 1'b0, 1'b1);
        // R6 R10: memory variant, D2 and A2 only, start while busy
        run_op(1'b0, 4'b1010, 32'h0000_8000, 8'h2C, 32'h3333_4444, 1'b1, 1'b1, 1'b0);
        // R2 R5: fast variant, D3 and A3, 0xFF adjust with wrap-around
        run_op(1'b1, 4'b0101, 32'hFFFF_FFC0, 8'hFF, 32'h5555_6666, 1'b1, 1'b0, 1'b0);
        // R9: stray answers while idle leave every output quiet
        g_spur = 1'b1;
        repeat (4) step();
        g_spur = 1'b0;
        // R4 R6: memory variant, full list, stalling port
        run_op(1'b0, 4'b1111, 32'h0001_0000, 8'h00, 32'h7777_8888, 1'b1, 1'b0, 1'b1);
        repeat (2) step();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule